// File: doc/BRIEF.md
# Stalling FIFO Read Port with Deadline

This block sits between a processor's memory-mapped bus and the read side of a first-word-fall-through FIFO. The bus raises a read or write chip-enable and holds it until the block answers with a one-cycle acknowledge. A new access is recognised only on the rising edge of a chip-enable, so an enable that stays high counts as one access.

A data read against a FIFO that holds a word is answered one cycle later. The word is returned and the FIFO is popped in the same cycle. If the FIFO is empty, the block withholds the acknowledge and waits for the producer to deliver a word. A wait counter bounds the stall well below the bus deadline. When the counter runs out, the block acknowledges anyway. It raises an error flag and returns a fixed marker word, so software can reject the read without a second bus access. A second address returns the FIFO's fill count, which lets software drain exactly that many words in a loop. Writes are acknowledged and otherwise ignored.

Top module: `fifo_rd_port`

## Requirements
- R1: While reset is high, and in the cycle after it, `bus_ack`, `bus_err` and `fifo_pop` are low and `bus_rd_data` is zero.
- R2: A read with `bus_sel` = 1 is acknowledged in the cycle after its start, even when the FIFO is empty. `bus_rd_data` carries `fifo_count`, zero-extended into the low bits and sampled in the start cycle. There is no pop and `bus_err` is low.
- R3: A read with `bus_sel` = 0 that starts while `fifo_empty` is low is acknowledged in the next cycle, with `fifo_pop` high in that same cycle. `bus_rd_data` equals the `fifo_data` head seen in the start cycle, and `bus_err` is low.
- R4: Only a rising edge of `bus_rd_ce` or `bus_wr_ce` starts an access. `bus_ack` and `fifo_pop` are single-cycle pulses, and a chip-enable held high after its acknowledge produces no further acknowledge.
- R5: While a data read waits on an empty FIFO, `bus_ack`, `bus_err` and `fifo_pop` stay low.
- R6: Consider a waiting data read that starts in cycle t. If `fifo_empty` is low in cycle t+k, for any k from 1 to `WAIT_LIMIT`, the read is served as in R3 in cycle t+k+1, with the newly arrived word.
- R7: If `fifo_empty` stays high from cycle t through cycle t+`WAIT_LIMIT`, then in cycle t+`WAIT_LIMIT`+1 `bus_ack` and `bus_err` are high together and `bus_rd_data` equals `DUMMY_WORD`. There is no pop, and a word that arrives later stays in the FIFO.
- R8: A write start is acknowledged in the next cycle with `bus_err` low, `fifo_pop` low and `bus_rd_data` zero. The FIFO count is left unchanged.
- R9: Every read is acknowledged no more than `WAIT_LIMIT`+1 cycles after its start, which is at most 121 cycles with the default limit.
- R10: The wait window restarts for each access. A stalled read that follows a timeout or a served wait receives the full `WAIT_LIMIT` window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd_ce | input | 1 | Read chip-enable, held until acknowledged |
| bus_wr_ce | input | 1 | Write chip-enable, held until acknowledged |
| bus_sel | input | 1 | Address select: 0 = FIFO data, 1 = fill count |
| bus_rd_data | output | DATA_W | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_err | output | 1 | Timeout flag, high only together with `bus_ack` |
| fifo_data | input | DATA_W | FIFO head word (first-word-fall-through) |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | One-cycle pop request |
| fifo_count | input | CNT_W | FIFO fill level |

## Verification
The bench builds the port with `WAIT_LIMIT` = 12, `CNT_W` = 6 and a marker word of 32'hBAD0_C0DE. The short window brings timeouts within 13 cycles. It also lets one run cover a word arriving at the last waiting cycle, a word arriving one cycle too late, and two timeouts in a row. The distinct marker value keeps the timeout response apart from any word the bench pushes.

// File: rtl/fifo_rd_port_pkg.sv
package fifo_rd_port_pkg;

  // Kind of response the port issues on the next cycle
  typedef enum logic [2:0] {
    RSP_NONE,
    RSP_DATA,
    RSP_COUNT,
    RSP_WRITE,
    RSP_TIMEOUT
  } rsp_e;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } st_e;

endpackage

// File: rtl/fifo_rd_port_edge.sv
// Rising-edge detection for a group of level inputs
module fifo_rd_port_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] lvl_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) lvl_q[i] <= 1'b0;
      else     lvl_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~lvl_q[i];
  end

endmodule

// File: rtl/fifo_rd_port_timer.sv
// Wait counter: load starts at one, inc advances, expired marks the limit
module fifo_rd_port_timer #(
  parameter int WAIT_LIMIT = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic inc,
  output logic expired
);

  localparam int TW = $clog2(WAIT_LIMIT + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= TW'(1);
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == TW'(WAIT_LIMIT));

endmodule

// File: rtl/fifo_rd_port_ctrl.sv
// Access sequencer: decides the response for the next cycle
module fifo_rd_port_ctrl
  import fifo_rd_port_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_rise,
  input  logic wr_rise,
  input  logic sel_cnt,
  input  logic fifo_empty,
  input  logic expired,
  output rsp_e kind,
  output logic tmr_load,
  output logic tmr_inc
);

  st_e st, st_nx;

  always_comb begin
    st_nx    = st;
    kind     = RSP_NONE;
    tmr_load = 1'b0;
    tmr_inc  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (rd_rise) begin
          if (sel_cnt)          kind = RSP_COUNT;
          else if (!fifo_empty) kind = RSP_DATA;
          else begin
            st_nx    = ST_WAIT;
            tmr_load = 1'b1;
          end
        end else if (wr_rise) begin
          kind = RSP_WRITE;
        end
      end
      ST_WAIT: begin
        if (!fifo_empty) begin
          kind  = RSP_DATA;
          st_nx = ST_IDLE;
        end else if (expired) begin
          kind  = RSP_TIMEOUT;
          st_nx = ST_IDLE;
        end else begin
          tmr_inc = 1'b1;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

endmodule

// File: rtl/fifo_rd_port_resp.sv
// Registered bus and FIFO outputs
module fifo_rd_port_resp
  import fifo_rd_port_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              CNT_W      = 8,
  parameter logic [DATA_W-1:0] DUMMY_WORD = 32'hDEAD_BEEF
) (
  input  logic              clk,
  input  logic              rst,
  input  rsp_e              kind,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic [CNT_W-1:0]  fifo_count,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack,
  output logic              err,
  output logic              pop
);

  logic [DATA_W-1:0] data_nx;

  always_comb begin
    unique case (kind)
      RSP_DATA:    data_nx = fifo_data;
      RSP_COUNT:   data_nx = DATA_W'(fifo_count);
      RSP_TIMEOUT: data_nx = DUMMY_WORD;
      default:     data_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      ack     <= 1'b0;
      err     <= 1'b0;
      pop     <= 1'b0;
    end else begin
      rd_data <= data_nx;
      ack     <= (kind != RSP_NONE);
      err     <= (kind == RSP_TIMEOUT);
      pop     <= (kind == RSP_DATA);
    end
  end

endmodule

// File: rtl/fifo_rd_port.sv
module fifo_rd_port
  import fifo_rd_port_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                CNT_W      = 8,
  parameter int                WAIT_LIMIT = 120,
  parameter logic [DATA_W-1:0] DUMMY_WORD = 32'hDEAD_BEEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd_ce,
  input  logic              bus_wr_ce,
  input  logic              bus_sel,
  output logic [DATA_W-1:0] bus_rd_data,
  output logic              bus_ack,
  output logic              bus_err,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic [CNT_W-1:0]  fifo_count
);

  localparam int N_CE = 2;

  logic [N_CE-1:0] ce_rise;
  logic            expired, tmr_load, tmr_inc;
  rsp_e            kind;

  fifo_rd_port_edge #(.N(N_CE)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({bus_wr_ce, bus_rd_ce}),
    .rise (ce_rise)
  );

  fifo_rd_port_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .inc     (tmr_inc),
    .expired (expired)
  );

  fifo_rd_port_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rd_rise    (ce_rise[0]),
    .wr_rise    (ce_rise[1]),
    .sel_cnt    (bus_sel),
    .fifo_empty (fifo_empty),
    .expired    (expired),
    .kind       (kind),
    .tmr_load   (tmr_load),
    .tmr_inc    (tmr_inc)
  );

  fifo_rd_port_resp #(
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .DUMMY_WORD (DUMMY_WORD)
  ) u_resp (
    .clk        (clk),
    .rst        (rst),
    .kind       (kind),
    .fifo_data  (fifo_data),
    .fifo_count (fifo_count),
    .rd_data    (bus_rd_data),
    .ack        (bus_ack),
    .err        (bus_err),
    .pop        (fifo_pop)
  );

endmodule

// File: rtl/fifo_rd_port_chk.sv
module fifo_rd_port_chk #(
  parameter int                DATA_W     = 32,
  parameter int                CNT_W      = 8,
  parameter int                WAIT_LIMIT = 120,
  parameter logic [DATA_W-1:0] DUMMY_WORD = 32'hDEAD_BEEF
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd_ce,
  input logic              bus_wr_ce,
  input logic [DATA_W-1:0] bus_rd_data,
  input logic              bus_ack,
  input logic              bus_err,
  input logic [DATA_W-1:0] fifo_data,
  input logic              fifo_empty,
  input logic              fifo_pop
);

  localparam int LW = $clog2(WAIT_LIMIT + 3) + 1;

  logic          rd_q, wr_q, pend;
  logic [LW-1:0] lat;
  logic          rd_rise, wr_rise;

  assign rd_rise = bus_rd_ce & ~rd_q;
  assign wr_rise = bus_wr_ce & ~wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      pend <= 1'b0;
      lat  <= '0;
    end else begin
      rd_q <= bus_rd_ce;
      wr_q <= bus_wr_ce;
      if (bus_ack) begin
        pend <= 1'b0;
        lat  <= '0;
      end else if (rd_rise) begin
        pend <= 1'b1;
        lat  <= LW'(1);
      end else if (pend) begin
        lat <= lat + 1'b1;
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!bus_ack && !bus_err && !fifo_pop));

  assert_pop_has_ack_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (bus_ack && !bus_err));

  assert_pop_word_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (bus_rd_data == $past(fifo_data) && !$past(fifo_empty)));

  assert_ack_single_R4: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  assert_timeout_marker_R7: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_ack && !fifo_pop && bus_rd_data == DUMMY_WORD));

  assert_write_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && !pend && !rd_rise) |=> (bus_ack && !bus_err && !fifo_pop));

  assert_deadline_bound_R9: assert property (@(posedge clk) disable iff (rst)
    pend |-> (lat <= LW'(WAIT_LIMIT + 1)));

  assert_deadline_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (pend && lat == LW'(WAIT_LIMIT + 1)) |-> bus_ack);

endmodule

bind fifo_rd_port fifo_rd_port_chk #(
  .DATA_W     (DATA_W),
  .CNT_W      (CNT_W),
  .WAIT_LIMIT (WAIT_LIMIT),
  .DUMMY_WORD (DUMMY_WORD)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_rd_ce   (bus_rd_ce),
  .bus_wr_ce   (bus_wr_ce),
  .bus_rd_data (bus_rd_data),
  .bus_ack     (bus_ack),
  .bus_err     (bus_err),
  .fifo_data   (fifo_data),
  .fifo_empty  (fifo_empty),
  .fifo_pop    (fifo_pop)
);

// File: tb/fifo_rd_port_tb.sv
module fifo_rd_port_tb;

  localparam int              CLK_PERIOD = 10;
  localparam int              DW  = 32;
  localparam int              CW  = 6;
  localparam int              LIM = 12;
  localparam logic [DW-1:0]   DUM = 32'hBAD0_C0DE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_ce = 1'b0, wr_ce = 1'b0, sel = 1'b0;
  logic [DW-1:0] f_data = '0;
  logic          f_empty = 1'b1;
  logic [CW-1:0] f_count = '0;
  logic [DW-1:0] rd_data;
  logic          ack, err, pop;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_rd_port #(
    .DATA_W(DW), .CNT_W(CW), .WAIT_LIMIT(LIM), .DUMMY_WORD(DUM)
  ) u_dut (
    .clk(clk), .rst(rst), .bus_rd_ce(rd_ce), .bus_wr_ce(wr_ce), .bus_sel(sel),
    .bus_rd_data(rd_data), .bus_ack(ack), .bus_err(err),
    .fifo_data(f_data), .fifo_empty(f_empty), .fifo_pop(pop), .fifo_count(f_count)
  );

  // Behavioural FIFO and port model
  logic [DW-1:0] q[$];
  bit    m_prev_rd, m_prev_wr, m_busy;
  int    m_wcnt;
  bit    e_ack, e_err, e_pop;
  logic [DW-1:0] e_data = '0;
  string e_tag = "R1";
  bit    got_ack;
  int    n_chk = 0, n_bad = 0;

  task automatic check();
    n_chk++;
    if (ack !== e_ack || pop !== e_pop || err !== e_err || rd_data !== e_data) begin
      n_bad++;
      $display("FAIL %s: ack/pop/err/data = %0b/%0b/%0b/%h expected %0b/%0b/%0b/%h",
               e_tag, ack, pop, err, rd_data, e_ack, e_pop, e_err, e_data);
    end
    got_ack = (ack === 1'b1);
  endtask

  task automatic refresh_fifo();
    f_empty = (q.size() == 0);
    f_data  = (q.size() == 0) ? '0 : q[0];
    f_count = CW'(q.size());
  endtask

  task automatic model();
    bit rs, ws;
    e_ack = 0; e_err = 0; e_pop = 0; e_data = '0;
    if (rst) begin
      m_prev_rd = 0; m_prev_wr = 0; m_busy = 0; m_wcnt = 0;
      e_tag = "R1";
      return;
    end
    rs = rd_ce && !m_prev_rd;
    ws = wr_ce && !m_prev_wr;
    m_prev_rd = rd_ce;
    m_prev_wr = wr_ce;
    e_tag = m_busy ? "R5" : "R4";
    if (m_busy) begin
      if (q.size() != 0) begin
        e_ack = 1; e_pop = 1; e_data = q[0]; m_busy = 0; e_tag = "R6";
      end else if (m_wcnt == LIM) begin
        e_ack = 1; e_err = 1; e_data = DUM; m_busy = 0; e_tag = "R7";
      end else begin
        m_wcnt++;
      end
    end else if (rs) begin
      if (sel) begin
        e_ack = 1; e_data = DW'(q.size()); e_tag = "R2";
      end else if (q.size() != 0) begin
        e_ack = 1; e_pop = 1; e_data = q[0]; e_tag = "R3";
      end else begin
        m_busy = 1; m_wcnt = 1;
      end
    end else if (ws) begin
      e_ack = 1; e_tag = "R8";
    end
  endtask

  task automatic cycle(bit r, bit rd, bit wr, bit s, bit push, logic [DW-1:0] w);
    @(negedge clk);
    check();
    if (e_pop && q.size() != 0) void'(q.pop_front());
    if (push) q.push_back(w);
    rst = r; rd_ce = rd; wr_ce = wr; sel = s;
    refresh_fifo();
    model();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, '0);
  endtask

  task automatic push_word(logic [DW-1:0] w);
    cycle(0, 0, 0, 0, 1, w);
  endtask

  // Read access held until acknowledged; word pushed push_k cycles after start
  task automatic do_read(bit s, int push_k, logic [DW-1:0] w, int hold, output int lat);
    lat = 0;
    cycle(0, 1, 0, s, push_k == 0, w);
    got_ack = 0;
    while (!got_ack && lat < 4 * LIM) begin
      lat++;
      cycle(0, 1, 0, s, push_k == lat, w);
    end
    for (int i = 0; i < hold; i++) cycle(0, 1, 0, s, 0, '0);
    cycle(0, 0, 0, 0, 0, '0);
  endtask

  task automatic lat_check(string tag, int lat, int exp_lat);
    n_chk++;
    if (lat != exp_lat || lat > LIM + 1) begin
      n_bad++;
      $display("FAIL %s: latency %0d expected %0d", tag, lat, exp_lat);
    end
  endtask

  task automatic q_check(string tag, int exp_n);
    n_chk++;
    if (q.size() != exp_n) begin
      n_bad++;
      $display("FAIL %s: fifo words %0d expected %0d", tag, q.size(), exp_n);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int lat;
    // R1: reset state
    for (int i = 0; i < 3; i++) cycle(1, 0, 0, 0, 0, '0);
    idle(3);                                    // R4 idle: no ack
    push_word(32'h1111_0001);
    push_word(32'h2222_0002);
    push_word(32'h3333_0003);
    idle(1);
    do_read(1, -1, '0, 0, lat);                 // R2 count = 3
    lat_check("R2", lat, 1);
    do_read(0, -1, '0, 0, lat);                 // R3 immediate data
    lat_check("R3", lat, 1);
    do_read(0, -1, '0, 5, lat);                 // R4 held enable, single ack
    q_check("R4", 1);
    // R8: write acknowledged and ignored
    cycle(0, 0, 1, 0, 0, '0);
    cycle(0, 0, 1, 0, 0, '0);
    cycle(0, 0, 0, 0, 0, '0);
    q_check("R8", 1);
    do_read(1, -1, '0, 0, lat);                 // R8 count unchanged
    do_read(0, -1, '0, 0, lat);                 // drain last word
    q_check("R3", 0);
    // R5/R6: word arrives mid-wait
    do_read(0, 5, 32'hA5A5_0005, 0, lat);
    lat_check("R6", lat, 6);
    // R6 boundary: word arrives in last waiting cycle
    do_read(0, LIM, 32'hA5A5_000C, 0, lat);
    lat_check("R6", lat, LIM + 1);
    // R7/R9: timeout with marker
    do_read(0, -1, '0, 0, lat);
    lat_check("R7", lat, LIM + 1);
    // R7: word one cycle late stays in FIFO
    do_read(0, LIM + 1, 32'h5A5A_0077, 0, lat);
    lat_check("R9", lat, LIM + 1);
    q_check("R7", 1);
    do_read(1, -1, '0, 0, lat);                 // R7 count shows the late word
    do_read(0, -1, '0, 0, lat);                 // R3 late word served
    // R10: back-to-back timeouts each get a full window
    do_read(0, -1, '0, 0, lat);
    lat_check("R10", lat, LIM + 1);
    do_read(0, -1, '0, 0, lat);
    lat_check("R10", lat, LIM + 1);
    do_read(1, -1, '0, 0, lat);                 // R2 count on empty, no stall
    lat_check("R2", lat, 1);
    idle(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule